// File: doc/BRIEF.md
# Fault-Rate Classifier

This block watches page-fault events and sorts each one for working-set management. It counts process-time ticks between faults. At every fault it compares the measured gap with a programmable minimum gap. A short gap means faults are arriving quickly, which points to a program moving into a new phase, so the block asks for one more page. A gap at or above the minimum means behaviour is steady, so the block asks for the least-recently-used page to be swapped out for the new one.

The comparison works on intervals rather than rates, so no divider is needed. A separate tracker counts unbroken runs of steady faults. When a run reaches a programmed length, the block raises a one-cycle request to shrink the working set. Software owns the actual page choice and the allocation. It reads one decision per fault through a valid strobe.

Top module: `fault_rate_classifier`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `dec_valid_o`, `dec_grow_o`, `shrink_o` and `interval_o` are all zero.
- R2: `interval_o` reports the number of cycles with `tick_i` high, counted from the previous fault's cycle (inclusive) up to the current fault's cycle (exclusive). A tick in the same cycle as a fault therefore belongs to the next interval.
- R3: The first fault after reset records its time only. `dec_valid_o` stays low for it and the stable-run count does not change.
- R4: For each later fault, `dec_valid_o` is high for exactly one cycle, in the cycle after the fault cycle, and all outputs are registered.
- R5: A fault whose interval is strictly less than `min_interval_i` produces `dec_grow_o` = 1, meaning add a page.
- R6: A fault whose interval is greater than or equal to `min_interval_i` produces `dec_grow_o` = 0, meaning replace the least-recently-used page.
- R7: The tick counter saturates at 2^CNT_W-1 and does not wrap.
- R8: When a replace decision makes the count of consecutive replace decisions reach `calm_count_i` (nonzero), `shrink_o` pulses for one cycle together with that decision. The count then restarts from zero.
- R9: A grow decision clears the consecutive replace count.
- R10: When `calm_count_i` is zero, `shrink_o` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One process-time tick per cycle when high |
| fault_i | input | 1 | Page-fault pulse |
| min_interval_i | input | CNT_W | Gaps shorter than this mean a high fault rate |
| calm_count_i | input | CALM_W | Consecutive replace decisions that trigger a shrink; 0 disables shrinking |
| dec_valid_o | output | 1 | Decision strobe, one cycle per classified fault |
| dec_grow_o | output | 1 | 1 = add a page, 0 = replace the least-recently-used page |
| shrink_o | output | 1 | One-cycle request to reduce the working set |
| interval_o | output | CNT_W | Measured tick gap of the latest fault |

## Verification
Four properties are checked every cycle. A strobe must follow a fault. The first fault after reset must stay silent. A shrink must ride on a replace decision. A zero run length must never shrink. The grow/replace choice is also checked against the reported interval and the threshold as it stood during the fault cycle. Some behaviours show only in the bench's directed sequences: exact tick counts, including a tick that lands on a fault cycle, counter saturation, the equal-to-threshold case, and the run count restarting after a shrink or a grow.

// File: rtl/frc_pkg.sv
package frc_pkg;

    typedef enum logic {
        DEC_REPLACE = 1'b0,
        DEC_GROW    = 1'b1
    } frc_decision_e;

    typedef struct packed {
        logic          valid;
        frc_decision_e kind;
        logic          shrink;
    } frc_verdict_t;

    // Short gap between faults means the fault rate is above the threshold.
    function automatic frc_decision_e classify_gap(input logic [31:0] gap,
                                                   input logic [31:0] limit);
        return (gap < limit) ? DEC_GROW : DEC_REPLACE;
    endfunction

endpackage

// File: rtl/frc_interval_timer.sv
module frc_interval_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             fault_i,
    output logic [CNT_W-1:0] gap_o
);
    localparam logic [CNT_W-1:0] GAP_MAX = '1;
    localparam logic [CNT_W-1:0] GAP_ONE = CNT_W'(1);

    logic [CNT_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= '0;
        end else if (fault_i) begin
            gap_q <= tick_i ? GAP_ONE : '0;
        end else if (tick_i && gap_q != GAP_MAX) begin
            gap_q <= gap_q + GAP_ONE;
        end
    end

    assign gap_o = gap_q;
endmodule

// File: rtl/frc_calm_tracker.sv
module frc_calm_tracker #(
    parameter int CALM_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              event_i,
    input  logic              grow_i,
    input  logic [CALM_W-1:0] limit_i,
    output logic              fire_o
);
    localparam int            EXT_W   = CALM_W + 1;
    localparam logic [EXT_W-1:0] EXT_ONE = EXT_W'(1);

    logic [CALM_W-1:0] run_q;
    logic [EXT_W-1:0]  run_next;
    logic              limit_on;

    always_comb begin
        run_next = {1'b0, run_q} + EXT_ONE;
        limit_on = (limit_i != '0);
        fire_o   = event_i && !grow_i && limit_on && (run_next >= {1'b0, limit_i});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (event_i) begin
            if (grow_i || fire_o) begin
                run_q <= '0;
            end else if (run_next[CALM_W] == 1'b0) begin
                run_q <= run_next[CALM_W-1:0];
            end
        end
    end
endmodule

// File: rtl/fault_rate_classifier.sv
module fault_rate_classifier
    import frc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int CALM_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              fault_i,
    input  logic [CNT_W-1:0]  min_interval_i,
    input  logic [CALM_W-1:0] calm_count_i,
    output logic              dec_valid_o,
    output logic              dec_grow_o,
    output logic              shrink_o,
    output logic [CNT_W-1:0]  interval_o
);
    logic             armed_q;
    logic             classify_evt;
    logic [CNT_W-1:0] gap;
    frc_decision_e    kind;
    logic             calm_fire;
    frc_verdict_t     verdict_d, verdict_q;
    logic [CNT_W-1:0] interval_q;

    frc_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick_i),
        .fault_i (fault_i),
        .gap_o   (gap)
    );

    assign classify_evt = fault_i && armed_q;
    assign kind = classify_gap(32'(gap), 32'(min_interval_i));

    frc_calm_tracker #(.CALM_W(CALM_W)) u_calm (
        .clk     (clk),
        .rst     (rst),
        .event_i (classify_evt),
        .grow_i  (kind == DEC_GROW),
        .limit_i (calm_count_i),
        .fire_o  (calm_fire)
    );

    always_comb begin
        verdict_d.valid  = classify_evt;
        verdict_d.kind   = classify_evt ? kind : verdict_q.kind;
        verdict_d.shrink = calm_fire;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q    <= 1'b0;
            verdict_q  <= '0;
            interval_q <= '0;
        end else begin
            if (fault_i) armed_q <= 1'b1;
            verdict_q <= verdict_d;
            if (classify_evt) interval_q <= gap;
        end
    end

    assign dec_valid_o = verdict_q.valid;
    assign dec_grow_o  = (verdict_q.kind == DEC_GROW);
    assign shrink_o    = verdict_q.shrink;
    assign interval_o  = interval_q;
endmodule

// File: rtl/frc_checker.sv
module frc_checker #(
    parameter int CNT_W  = 16,
    parameter int CALM_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              fault_i,
    input logic [CNT_W-1:0]  min_interval_i,
    input logic [CALM_W-1:0] calm_count_i,
    input logic              dec_valid_o,
    input logic              dec_grow_o,
    input logic              shrink_o,
    input logic [CNT_W-1:0]  interval_o
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else if (fault_i) seen_q <= 1'b1;
    end

    p_first_fault_silent_r3: assert property (@(posedge clk) disable iff (rst)
        (fault_i && !seen_q) |=> !dec_valid_o);

    p_strobe_follows_fault_r4: assert property (@(posedge clk) disable iff (rst)
        dec_valid_o |-> $past(fault_i));

    p_grow_vs_threshold_r5: assert property (@(posedge clk) disable iff (rst)
        dec_valid_o |-> (dec_grow_o == (interval_o < $past(min_interval_i))));

    p_shrink_on_replace_r8: assert property (@(posedge clk) disable iff (rst)
        shrink_o |-> (dec_valid_o && !dec_grow_o));

    p_zero_run_no_shrink_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(calm_count_i) == '0) |-> !shrink_o);
endmodule

bind fault_rate_classifier frc_checker #(.CNT_W(CNT_W), .CALM_W(CALM_W)) i_frc_checker (
    .clk            (clk),
    .rst            (rst),
    .fault_i        (fault_i),
    .min_interval_i (min_interval_i),
    .calm_count_i   (calm_count_i),
    .dec_valid_o    (dec_valid_o),
    .dec_grow_o     (dec_grow_o),
    .shrink_o       (shrink_o),
    .interval_o     (interval_o)
);

// File: tb/test_fault_rate_classifier.sv
module test_fault_rate_classifier;
    localparam int CNT_W  = 8;
    localparam int CALM_W = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick_i = 1'b0;
    logic              fault_i = 1'b0;
    logic [CNT_W-1:0]  min_interval_i = '0;
    logic [CALM_W-1:0] calm_count_i = '0;
    logic              dec_valid_o, dec_grow_o, shrink_o;
    logic [CNT_W-1:0]  interval_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    fault_rate_classifier #(.CNT_W(CNT_W), .CALM_W(CALM_W)) i_fault_rate_classifier (
        .clk(clk), .rst(rst), .tick_i(tick_i), .fault_i(fault_i),
        .min_interval_i(min_interval_i), .calm_count_i(calm_count_i),
        .dec_valid_o(dec_valid_o), .dec_grow_o(dec_grow_o),
        .shrink_o(shrink_o), .interval_o(interval_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // n cycles with tick high; returns at a negedge with tick low.
    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_i = 1'b1;
        end
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    // n ticks, then one fault cycle (optionally with a tick); returns when outputs are visible.
    task automatic fault_after(input int n, input logic tick_with);
        run_ticks(n);
        fault_i = 1'b1;
        tick_i  = tick_with;
        @(negedge clk);
        fault_i = 1'b0;
        tick_i  = 1'b0;
    endtask

    task automatic expect_dec(input string req, input int iv, input int grow, input int shr);
        check({req, " valid"}, int'(dec_valid_o), 1);
        check({req, " interval"}, int'(interval_o), iv);
        check({req, " grow"}, int'(dec_grow_o), grow);
        check({req, " shrink"}, int'(shrink_o), shr);
    endtask

    task automatic test_reset_r1();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid", int'(dec_valid_o), 0);
        check("R1 grow", int'(dec_grow_o), 0);
        check("R1 shrink", int'(shrink_o), 0);
        check("R1 interval", int'(interval_o), 0);
    endtask

    task automatic test_first_and_grow_r3_r5();
        min_interval_i = 8'd10;
        calm_count_i   = 4'd0;
        fault_after(5, 1'b0);
        check("R3 first fault silent", int'(dec_valid_o), 0);
        fault_after(3, 1'b0);
        expect_dec("R5 short gap grows (R2 count)", 3, 1, 0);
        @(negedge clk);
        check("R4 strobe one cycle", int'(dec_valid_o), 0);
    endtask

    task automatic test_replace_equal_r6();
        min_interval_i = 8'd4;
        fault_after(4, 1'b0);
        expect_dec("R6 equal gap replaces", 4, 0, 0);
        fault_after(9, 1'b0);
        expect_dec("R6 long gap replaces", 9, 0, 0);
    endtask

    task automatic test_tick_on_fault_r2();
        fault_after(1, 1'b1);
        expect_dec("R2 gap before", 1, 1, 0);
        fault_after(2, 1'b0);
        expect_dec("R2 tick on fault cycle counted next", 3, 1, 0);
    endtask

    task automatic test_saturate_r7();
        fault_after(300, 1'b0);
        expect_dec("R7 saturated gap", 255, 0, 0);
    endtask

    task automatic test_shrink_r8_r9();
        min_interval_i = 8'd4;
        calm_count_i   = 4'd3;
        fault_after(1, 1'b0);
        expect_dec("R9 grow clears run", 1, 1, 0);
        fault_after(6, 1'b0);
        expect_dec("R8 run 1", 6, 0, 0);
        fault_after(6, 1'b0);
        expect_dec("R8 run 2", 6, 0, 0);
        fault_after(6, 1'b0);
        expect_dec("R8 run 3 shrinks", 6, 0, 1);
        @(negedge clk);
        check("R8 shrink one cycle", int'(shrink_o), 0);
        fault_after(6, 1'b0);
        expect_dec("R8 restart after shrink", 6, 0, 0);
        fault_after(6, 1'b0);
        expect_dec("R8 run 2 again", 6, 0, 0);
        fault_after(2, 1'b0);
        expect_dec("R9 grow breaks run", 2, 1, 0);
        fault_after(6, 1'b0);
        expect_dec("R9 run 1 after grow", 6, 0, 0);
        fault_after(6, 1'b0);
        expect_dec("R9 run 2 after grow", 6, 0, 0);
        fault_after(6, 1'b0);
        expect_dec("R9 run 3 shrinks", 6, 0, 1);
    endtask

    task automatic test_disabled_r10();
        calm_count_i = 4'd0;
        fault_after(1, 1'b0);
        expect_dec("R10 grow", 1, 1, 0);
        for (int k = 0; k < 5; k++) begin
            fault_after(7, 1'b0);
            expect_dec("R10 no shrink when run length zero", 7, 0, 0);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        test_reset_r1();
        test_first_and_grow_r3_r5();
        test_replace_equal_r6();
        test_tick_on_fault_r2();
        test_saturate_r7();
        test_shrink_r8_r9();
        test_disabled_r10();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule